// File: doc/BRIEF.md
# Multi-Mode Built-In Test Observation Register

This block is a register of configurable width meant to sit between two blocks of combinational logic. In functional operation it behaves as a plain parallel-load register. For test, the same flip-flops can be put into one of three other roles:

- a serial scan chain, used to seed or dump its contents;
- a linear feedback shift register that steps through a maximal-length pseudo-random sequence and drives the logic downstream;
- a parallel-input signature compactor that folds a stream of upstream responses into one residue.

A fourth code clears every stage.

A two-bit mode code selects the role on every clock. One XOR feedback term into the first stage serves both the pattern-generation role and the compaction role. Pattern generation is simply compaction with the parallel inputs held at zero. The all-zero state maps onto itself in that role, so a test controller seeds the register with a non-zero value before it starts generating patterns. It does this by a parallel load or by scan.

Top module: `test_obs_reg`

## Requirements
- R1: While rst_n is low at a rising clock edge, every stage becomes 0 at that edge, whatever the mode code; par_out reads 0 and scan_out reads 0.
- R2: With mode_b1=1 and mode_b0=1 (load), each edge copies par_in into the stages, so that par_out equals the par_in of the previous cycle. par_out bit i is stage i.
- R3: With mode_b1=0 and mode_b0=0 (scan), each edge moves stage i-1 into stage i and takes scan_in into stage 0.
- R4: scan_out always shows the highest stage (par_out bit WIDTH-1). A scan of WIDTH cycles therefore presents the stored word on scan_out, highest stage first.
- R5: With mode_b1=1 and mode_b0=0 (clear), each edge sets every stage to 0 regardless of par_in and scan_in.
- R6: With mode_b1=0 and mode_b0=1 (compact) and par_in held at 0, the 3-stage register loads S1 XOR S2 into S0 and shifts S0 into S1 and S1 into S2. Starting from par_out=001 it visits 001, 010, 101, 011, 111, 110, 100 and then returns to 001, a period of 7.
- R7: In compact mode with non-zero data, stage 0 takes the feedback XOR par_in[0] and stage i takes stage i-1 XOR par_in[i]. The sequence below is the reference case:
  - start from the cleared state;
  - apply par_in = 101, 011, 110, 001 on four consecutive edges;
  - the register then holds par_out=101.
- R8: In compact mode with par_in=0, a register holding all zeros stays all zeros, and a register holding any non-zero value never reaches all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_b1 | input | 1 | Upper mode bit |
| mode_b0 | input | 1 | Lower mode bit |
| par_in | input | WIDTH | Parallel data from the upstream logic |
| scan_in | input | 1 | Serial input into stage 0 in scan mode |
| par_out | output | WIDTH | Current stage values, bit i is stage i |
| scan_out | output | 1 | Highest stage, serial output of the chain |

## Verification
Every result of this register appears one edge after the mode, data and scan bit that cause it. The one exception is scan_out, which follows the stage it mirrors with no delay of its own.

The driver changes inputs on the falling edge and queues the expected word for the rising edge that follows. The monitor compares that word 2 ns after the rising edge, so each queued item meets the single edge it describes. Sequence-level results are checked at the same post-edge point, after the last edge of their stimulus: the seven-state walk, the four-word signature and the scan-out order.

// File: rtl/test_obs_pkg.sv
// Package: shared types and the feedback tap table for the test
// observation register. The tap table is assumed maximal for widths 2..8.
// Wider instances fall back to the two highest stages.
package test_obs_pkg;

    // Decoded role of the register for one clock cycle; exactly one flag is set.
    typedef struct packed {
        logic load;
        logic shift;
        logic compact;
        logic clear;
    } obs_role_t;

    // Feedback tap mask: bit k set means stage k feeds the XOR into stage 0.
    function automatic logic [31:0] tap_mask(input int unsigned width);
        logic [31:0] m;
        m = '0;
        case (width)
            2:       begin m[1] = 1'b1; m[0] = 1'b1; end
            3:       begin m[2] = 1'b1; m[1] = 1'b1; end
            4:       begin m[3] = 1'b1; m[2] = 1'b1; end
            5:       begin m[4] = 1'b1; m[2] = 1'b1; end
            6:       begin m[5] = 1'b1; m[4] = 1'b1; end
            7:       begin m[6] = 1'b1; m[5] = 1'b1; end
            8:       begin m[7] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
            default: begin m[width-1] = 1'b1; m[width-2] = 1'b1; end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/test_obs_mode_dec.sv
// Module: turns the two mode bits into a one-hot role.
// Codes {b1,b0}: 11 load, 00 scan, 01 compact/generate, 10 clear.
// Assumes the mode bits are synchronous to the register clock.
module test_obs_mode_dec
    import test_obs_pkg::*;
(
    input  logic      mode_b1,
    input  logic      mode_b0,
    output obs_role_t role
);

    // Decode the mode code into a single active role.
    always_comb begin
        role = '0;
        case ({mode_b1, mode_b0})
            2'b11:   role.load    = 1'b1;
            2'b00:   role.shift   = 1'b1;
            2'b01:   role.compact = 1'b1;
            default: role.clear   = 1'b1;
        endcase
    end

endmodule

// File: rtl/test_obs_feedback.sv
// Module: XOR feedback network of the register. It folds the tapped
// stages into one bit for stage 0. It is purely combinational and
// assumes WIDTH >= 2.
module test_obs_feedback
    import test_obs_pkg::*;
#(
    parameter int unsigned WIDTH = 3
) (
    input  logic [WIDTH-1:0] stages,
    output logic             fb_bit
);

    localparam logic [31:0] TAPS = tap_mask(WIDTH);

    logic [WIDTH-1:0] tapped;

    // Keep only the stages named by the tap mask.
    always_comb begin
        for (int k = 0; k < WIDTH; k++) begin
            tapped[k] = stages[k] & TAPS[k];
        end
    end

    // Reduce the tapped stages to the feedback bit.
    always_comb fb_bit = ^tapped;

endmodule

// File: rtl/test_obs_stage.sv
// Module: one storage stage of the register. The link input is the bit
// arriving from the previous stage, or from the head multiplexer for
// stage 0. Reset is synchronous and active low.
module test_obs_stage
    import test_obs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  obs_role_t role,
    input  logic      d_bit,
    input  logic      link_bit,
    output logic      q
);

    // Update the stage according to the active role.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (role.clear) begin
            q <= 1'b0;
        end else if (role.load) begin
            q <= d_bit;
        end else if (role.shift) begin
            q <= link_bit;
        end else if (role.compact) begin
            q <= link_bit ^ d_bit;
        end
    end

endmodule

// File: rtl/test_obs_reg.sv
// Module: top of the multi-mode test observation register. It provides
// parallel load, scan, pattern generation / signature compaction and
// clear in one chain of stages. Assumes WIDTH >= 2.
module test_obs_reg
    import test_obs_pkg::*;
#(
    parameter int unsigned WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_b1,
    input  logic             mode_b0,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] par_out,
    output logic             scan_out
);

    localparam int unsigned LAST = WIDTH - 1;

    obs_role_t        role;
    logic             fb_bit;
    logic             head_bit;
    logic [WIDTH-1:0] stages;

    test_obs_mode_dec u_dec (
        .mode_b1 (mode_b1),
        .mode_b0 (mode_b0),
        .role    (role)
    );

    test_obs_feedback #(.WIDTH(WIDTH)) u_fb (
        .stages (stages),
        .fb_bit (fb_bit)
    );

    // Head multiplexer: scan input in scan mode, otherwise the feedback bit.
    always_comb head_bit = role.shift ? scan_in : fb_bit;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            test_obs_stage u_st (
                .clk      (clk),
                .rst_n    (rst_n),
                .role     (role),
                .d_bit    (par_in[0]),
                .link_bit (head_bit),
                .q        (stages[0])
            );
        end else begin : g_body
            test_obs_stage u_st (
                .clk      (clk),
                .rst_n    (rst_n),
                .role     (role),
                .d_bit    (par_in[i]),
                .link_bit (stages[i-1]),
                .q        (stages[i])
            );
        end
    end

    // Drive the outputs straight from the stages.
    always_comb begin
        par_out  = stages;
        scan_out = stages[LAST];
    end

endmodule

// File: rtl/test_obs_reg_chk.sv
// Module: assertion checker for the test observation register, attached
// to every instance by the bind at the end of this file.
module test_obs_reg_chk #(
    parameter int unsigned WIDTH = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_b1,
    input logic             mode_b0,
    input logic [WIDTH-1:0] par_in,
    input logic             scan_in,
    input logic [WIDTH-1:0] par_out,
    input logic             scan_out
);

    // Reset clears the register on the edge where it is sampled low.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (par_out == '0 && scan_out == 1'b0));

    // Load mode copies the parallel input.
    p_load_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b1 && mode_b0) |=> par_out == $past(par_in));

    // Scan mode shifts up by one and takes the scan bit into stage 0.
    p_scan_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_b1 && !mode_b0) |=>
            (par_out[WIDTH-1:1] == $past(par_out[WIDTH-2:0]) &&
             par_out[0] == $past(scan_in)));

    // scan_out presents the bit one position below the top after a shift.
    p_scan_out_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_b1 && !mode_b0) |=> scan_out == $past(par_out[WIDTH-2]));

    // Clear mode zeroes every stage.
    p_clear_zeroes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_b1 && !mode_b0) |=> par_out == '0);

    // Compaction XORs each data bit into the shifted chain above stage 0.
    p_compact_body_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_b1 && mode_b0) |=>
            par_out[WIDTH-1:1] == ($past(par_out[WIDTH-2:0]) ^ $past(par_in[WIDTH-1:1])));

    // Zero-input generation keeps all-zero at zero.
    p_zero_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_b1 && mode_b0 && par_in == '0 && par_out == '0) |=> par_out == '0);

    // Zero-input generation never drops a non-zero state to zero.
    p_nonzero_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_b1 && mode_b0 && par_in == '0 && par_out != '0) |=> par_out != '0);

endmodule

bind test_obs_reg test_obs_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_b1  (mode_b1),
    .mode_b0  (mode_b0),
    .par_in   (par_in),
    .scan_in  (scan_in),
    .par_out  (par_out),
    .scan_out (scan_out)
);

// File: tb/test_obs_reg_tb_top.sv
`timescale 1ns/1ps
// Bench: scoreboard for the 3-stage test observation register.
module test_obs_reg_tb_top;

    localparam int W = 3;

    typedef struct {
        logic [W-1:0] q;
        logic         so;
        string        tag;
    } exp_item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_b1 = 1'b1;
    logic         mode_b0 = 1'b1;
    logic [W-1:0] par_in = '0;
    logic         scan_in = 1'b0;
    logic [W-1:0] par_out;
    logic         scan_out;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] model = '0;
    exp_item_t sb_q[$];

    test_obs_reg #(.WIDTH(W)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_b1  (mode_b1),
        .mode_b0  (mode_b0),
        .par_in   (par_in),
        .scan_in  (scan_in),
        .par_out  (par_out),
        .scan_out (scan_out)
    );

    // 100 MHz clock.
    always #5 clk = ~clk;

    // Next state from the requirements; mode code is {b1,b0}.
    function automatic logic [W-1:0] next_of(input logic [W-1:0] s, input logic r,
                                             input logic [1:0] m, input logic [W-1:0] d,
                                             input logic si);
        logic [W-1:0] n;
        if (!r) return '0;                                      // R1
        case (m)
            2'b11: n = d;                                       // R2
            2'b00: n = {s[1], s[0], si};                        // R3
            2'b10: n = '0;                                      // R5
            default: n = {s[1] ^ d[2], s[0] ^ d[1], (s[1] ^ s[2]) ^ d[0]}; // R6 R7
        endcase
        return n;
    endfunction

    // Driver: apply one cycle of stimulus on the falling edge and queue the result.
    task automatic step(input logic r, input logic [1:0] m, input logic [W-1:0] d,
                        input logic si, input string tag);
        exp_item_t it;
        @(negedge clk);
        rst_n = r; mode_b1 = m[1]; mode_b0 = m[0]; par_in = d; scan_in = si;
        model = next_of(model, r, m, d, si);
        it.q = model; it.so = model[W-1]; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Direct check of the outputs after the edge just driven.
    task automatic expect_now(input logic [W-1:0] q, input logic so, input string tag);
        @(posedge clk); #2;
        checks++;
        if (par_out !== q || scan_out !== so) begin
            errors++;
            $display("FAIL %s par_out=%b scan_out=%b expected par_out=%b scan_out=%b",
                     tag, par_out, scan_out, q, so);
        end
    endtask

    // Monitor: compare the queued expectation 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            checks++;
            if (par_out !== it.q || scan_out !== it.so) begin
                errors++;
                $display("FAIL %s par_out=%b scan_out=%b expected par_out=%b scan_out=%b",
                         it.tag, par_out, scan_out, it.q, it.so);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        logic [W-1:0] walk [8];
        logic [W-1:0] sig_words [4];
        walk[0] = 3'b001; walk[1] = 3'b010; walk[2] = 3'b101; walk[3] = 3'b011;
        walk[4] = 3'b111; walk[5] = 3'b110; walk[6] = 3'b100; walk[7] = 3'b001;
        sig_words[0] = 3'b101; sig_words[1] = 3'b011;
        sig_words[2] = 3'b110; sig_words[3] = 3'b001;

        // R1: reset state with a load code and non-zero data present.
        step(1'b0, 2'b11, 3'b111, 1'b1, "R1 reset");
        step(1'b0, 2'b11, 3'b111, 1'b1, "R1 reset");
        expect_now(3'b000, 1'b0, "R1 reset state");

        // R2: parallel loads.
        step(1'b1, 2'b11, 3'b010, 1'b0, "R2 load 010");
        step(1'b1, 2'b11, 3'b110, 1'b0, "R2 load 110");
        step(1'b1, 2'b11, 3'b001, 1'b0, "R2 load 001 seed");
        expect_now(3'b001, 1'b0, "R2 seed value");

        // R6: seven-state walk with zero data.
        for (int k = 1; k < 8; k++) begin
            step(1'b1, 2'b01, 3'b000, 1'b0, "R6 generate");
            expect_now(walk[k], walk[k][2], "R6 walk state");
        end

        // R5: clear ignores data and scan input.
        step(1'b1, 2'b10, 3'b111, 1'b1, "R5 clear");
        expect_now(3'b000, 1'b0, "R5 cleared");

        // R8: all-zero lock-up in generation.
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 2'b01, 3'b000, 1'b0, "R8 zero lock");
        end
        expect_now(3'b000, 1'b0, "R8 still zero");

        // R3: scan in 1,0,1.
        step(1'b1, 2'b00, 3'b111, 1'b1, "R3 scan in");
        step(1'b1, 2'b00, 3'b111, 1'b0, "R3 scan in");
        step(1'b1, 2'b00, 3'b111, 1'b1, "R3 scan in");
        expect_now(3'b101, 1'b1, "R3 scanned word");

        // R4: load 110 and shift it out, highest stage first.
        step(1'b1, 2'b11, 3'b110, 1'b0, "R4 load");
        expect_now(3'b110, 1'b1, "R4 first scan bit");
        step(1'b1, 2'b00, 3'b000, 1'b0, "R4 shift out");
        expect_now(3'b100, 1'b1, "R4 second scan bit");
        step(1'b1, 2'b00, 3'b000, 1'b0, "R4 shift out");
        expect_now(3'b000, 1'b0, "R4 third scan bit");

        // R7: signature of a fixed four-word stream from zero.
        step(1'b1, 2'b10, 3'b000, 1'b0, "R7 clear");
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 2'b01, sig_words[k], 1'b0, "R7 compact");
        end
        expect_now(3'b101, 1'b1, "R7 signature");

        // R1: reset in the middle of operation.
        step(1'b1, 2'b11, 3'b111, 1'b0, "R1 preload");
        step(1'b0, 2'b01, 3'b111, 1'b1, "R1 mid reset");
        expect_now(3'b000, 1'b0, "R1 mid reset cleared");

        step(1'b1, 2'b11, 3'b000, 1'b0, "R2 idle");
        @(posedge clk); #3;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule